// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block caches recent virtual-to-physical page translations for a 31-bit virtual address space and a 27-bit physical address space with 4 KB pages. A lookup presents a virtual address. In the same cycle, without any clock, the block compares the upper 19 bits (the virtual page number) against every stored entry in parallel. On a match it returns a hit flag and the physical address. The physical address is the matched 15-bit physical page number joined to the untouched 12-bit page offset.

Translations are loaded through a fill port, one per clock edge. A fill whose page number is already stored rewrites that entry. Otherwise the fill goes to the lowest-numbered empty entry, or, when every entry holds a translation, to the entry named by a round-robin victim pointer. A flush input empties the whole buffer in one edge. A miss is only reported; the requester must walk the page table and fill.

Top module: `xlat_buf`

## Requirements
- R1: After reset no entry is valid, so every lookup reports miss (lkHit = 0) and lkPaddr = 0.
- R2: Physical address bits [11:0] equal virtual address bits [11:0] on a hit. Bits [26:12] are the PPN of the matching entry. Example: VPN 0x00002 mapped to PPN 0x7FFF translates 0x247C to 0x7FFF47C.
- R3: Lookup is combinational: hit and address reflect the current lkVaddr and entry contents in the same cycle, with no register between them.
- R4: A lookup hits only if some valid entry stores exactly the VPN lkVaddr[30:12]. A miss drives lkPaddr to 0.
- R5: A fill (fillEn = 1 at a rising edge) whose VPN matches a valid entry overwrites that entry's PPN. No second entry is used, so entries never hold duplicate VPNs.
- R6: A fill with a new VPN goes into the lowest-indexed invalid entry if one exists.
- R7: A fill with a new VPN when all entries are valid replaces the entry at the victim pointer. The pointer starts at 0 after reset and advances by one (wrapping) after each such replacement, giving round-robin order.
- R8: flushAll = 1 at a rising edge clears every valid bit in that edge and takes priority over a simultaneous fill. The victim pointer is kept.
- R9: A fill with fillValid = 0 writes an entry whose valid bit is clear. That entry never hits, even though its VPN matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkVaddr | input | 31 | Lookup virtual address |
| lkHit | output | 1 | Lookup found a valid matching entry |
| lkPaddr | output | 27 | Translated physical address, 0 on miss |
| fillEn | input | 1 | Write a translation this edge |
| fillVpn | input | 19 | Virtual page number to store |
| fillPpn | input | 15 | Physical page number to store |
| fillValid | input | 1 | Valid bit written with the fill |
| flushAll | input | 1 | Clear all valid bits this edge |

## Verification
Lookup results are due in the same cycle as the address, so the bench drives lkVaddr after a falling edge and samples lkHit and lkPaddr a quarter period later, before the next rising edge. Fills and flushes take effect at the first rising edge they are held for. The bench therefore checks their consequence with a lookup in the following low phase. It keeps its own model of entries, valid bits and victim pointer, updated at that same edge. Random fills, flushes and lookups with a fixed seed are mixed with directed cases for invalid matching entries, overwrite of an existing VPN, and round-robin wrap.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VA_W  = 31;
  localparam int PA_W  = 27;
  localparam int OFF_W = 12;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;

  typedef struct packed {
    logic             valid;
    logic [VPN_W-1:0] vpn;
    logic [PPN_W-1:0] ppn;
  } entry_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAll;
    logic writeEn;
  } ctrl_t;
endpackage

// File: rtl/xlat_dp.sv
module xlat_dp
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 2,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_t              ctrl,
  input  logic [IDX_W-1:0]   writeIdx,
  input  logic [VPN_W-1:0]   fillVpn,
  input  logic [PPN_W-1:0]   fillPpn,
  input  logic               fillValid,
  input  logic [VA_W-1:0]    lkVaddr,
  output logic [ENTRIES-1:0] validVec,
  output logic [ENTRIES-1:0] fillMatch,
  output logic               lkHit,
  output logic [PA_W-1:0]    lkPaddr
);
  entry_t entries [ENTRIES];
  logic [ENTRIES-1:0] lkMatch;
  logic [VPN_W-1:0]   lkVpn;

  assign lkVpn = lkVaddr[VA_W-1:OFF_W];

  for (genvar g = 0; g < ENTRIES; g++) begin : gEntry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        entries[g] <= '0;
      end else if (ctrl.clearAll) begin
        entries[g].valid <= 1'b0;
      end else if (ctrl.writeEn && writeIdx == IDX_W'(g)) begin
        entries[g] <= '{valid: fillValid, vpn: fillVpn, ppn: fillPpn};
      end
    end
    assign validVec[g]  = entries[g].valid;
    assign lkMatch[g]   = entries[g].valid && entries[g].vpn == lkVpn;
    assign fillMatch[g] = entries[g].valid && entries[g].vpn == fillVpn;
  end

  always_comb begin
    logic [PPN_W-1:0] ppnSel;
    ppnSel = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lkMatch[i]) ppnSel = ppnSel | entries[i].ppn;
    end
    lkHit   = |lkMatch;
    lkPaddr = lkHit ? {ppnSel, lkVaddr[OFF_W-1:0]} : '0;
  end
endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 2,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fillEn,
  input  logic               flushAll,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] fillMatch,
  output ctrl_t              ctrl,
  output logic [IDX_W-1:0]   writeIdx,
  output logic [IDX_W-1:0]   victimPtr
);
  logic             anyMatch, anyFree, useVictim;
  logic [IDX_W-1:0] matchIdx, freeIdx;

  always_comb begin
    matchIdx = '0;
    freeIdx  = '0;
    anyMatch = 1'b0;
    anyFree  = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (fillMatch[i]) begin
        matchIdx = IDX_W'(i);
        anyMatch = 1'b1;
      end
      if (!validVec[i]) begin
        freeIdx = IDX_W'(i);
        anyFree = 1'b1;
      end
    end
    useVictim = !anyMatch && !anyFree;
    writeIdx  = anyMatch ? matchIdx : (anyFree ? freeIdx : victimPtr);
    ctrl.clearAll = flushAll;
    ctrl.writeEn  = fillEn && !flushAll;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      victimPtr <= '0;
    end else if (ctrl.writeEn && useVictim) begin
      victimPtr <= (victimPtr == IDX_W'(ENTRIES - 1)) ? '0 : victimPtr + 1'b1;
    end
  end
endmodule

// File: rtl/xlat_buf.sv
module xlat_buf #(
  parameter int ENTRIES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [30:0] lkVaddr,
  output logic        lkHit,
  output logic [26:0] lkPaddr,
  input  logic        fillEn,
  input  logic [18:0] fillVpn,
  input  logic [14:0] fillPpn,
  input  logic        fillValid,
  input  logic        flushAll
);
  import xlat_pkg::*;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  ctrl_t              ctrl;
  logic [IDX_W-1:0]   writeIdx, victimPtr;
  logic [ENTRIES-1:0] validVec, fillMatch;

  xlat_ctrl #(.ENTRIES(ENTRIES)) i_ctrl (
    .clk(clk), .rstN(rstN), .fillEn(fillEn), .flushAll(flushAll),
    .validVec(validVec), .fillMatch(fillMatch), .ctrl(ctrl),
    .writeIdx(writeIdx), .victimPtr(victimPtr)
  );

  xlat_dp #(.ENTRIES(ENTRIES)) i_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .writeIdx(writeIdx),
    .fillVpn(fillVpn), .fillPpn(fillPpn), .fillValid(fillValid),
    .lkVaddr(lkVaddr), .validVec(validVec), .fillMatch(fillMatch),
    .lkHit(lkHit), .lkPaddr(lkPaddr)
  );
endmodule

// File: rtl/xlat_buf_chk.sv
module xlat_buf_chk #(
  parameter int ENTRIES = 2
) (
  input logic        clk,
  input logic        rstN,
  input logic [30:0] lkVaddr,
  input logic        lkHit,
  input logic [26:0] lkPaddr,
  input logic        fillEn,
  input logic [18:0] fillVpn,
  input logic        fillValid,
  input logic        flushAll,
  input logic [ENTRIES-1:0] validVec,
  input logic [ENTRIES-1:0] fillMatch
);
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rstN)
    lkHit |-> lkPaddr[11:0] == lkVaddr[11:0]);                             // R2
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !lkHit |-> lkPaddr == '0);                                             // R4
  AST_NO_DUP: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(fillMatch));                                                  // R5
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    flushAll |=> validVec == '0);                                          // R8
  AST_NO_HIT_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    validVec == '0 |-> !lkHit);                                            // R9
  AST_MATCH_FILL_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (fillEn && !flushAll && fillValid && |fillMatch) |=> $countones(validVec) == $past($countones(validVec))); // R5
  always @(posedge clk) if (rstN && $past(!rstN)) AST_RESET_EMPTY: assert (validVec == '0); // R1
endmodule

bind xlat_buf xlat_buf_chk #(.ENTRIES(ENTRIES)) i_chk (
  .clk(clk), .rstN(rstN), .lkVaddr(lkVaddr), .lkHit(lkHit), .lkPaddr(lkPaddr),
  .fillEn(fillEn), .fillVpn(fillVpn), .fillValid(fillValid), .flushAll(flushAll),
  .validVec(validVec), .fillMatch(fillMatch)
);

// File: tb/test_xlat_buf.sv
module test_xlat_buf;
  localparam int CLK_PERIOD = 10;
  localparam int N = 2;

  logic        clk = 0, rstN = 0;
  logic [30:0] lkVaddr = '0;
  logic        lkHit;
  logic [26:0] lkPaddr;
  logic        fillEn = 0, fillValid = 0, flushAll = 0;
  logic [18:0] fillVpn = '0;
  logic [14:0] fillPpn = '0;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model
  logic        mV   [N];
  logic [18:0] mVpn [N];
  logic [14:0] mPpn [N];
  int          mPtr;

  xlat_buf #(.ENTRIES(N)) i_xlat_buf (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [27:0] expLookup(logic [30:0] va);
    for (int i = 0; i < N; i++)
      if (mV[i] && mVpn[i] == va[30:12]) return {1'b1, mPpn[i], va[11:0]};
    return '0;
  endfunction

  function automatic void modelFill(logic [18:0] v, logic [14:0] p, logic val);
    int idx = -1;
    for (int i = 0; i < N; i++) if (idx < 0 && mV[i] && mVpn[i] == v) idx = i;
    if (idx < 0) for (int i = 0; i < N; i++) if (idx < 0 && !mV[i]) idx = i;
    if (idx < 0) begin idx = mPtr; mPtr = (mPtr + 1) % N; end
    mV[idx] = val; mVpn[idx] = v; mPpn[idx] = p;
  endfunction

  task automatic check(string req, logic [30:0] va);
    logic [27:0] e;
    lkVaddr = va;
    #(CLK_PERIOD/4);
    e = expLookup(va);
    checks++;
    if ({lkHit, lkPaddr} !== e) begin
      errors++;
      $display("FAIL %s va=%h actual hit=%0b pa=%h expected hit=%0b pa=%h",
               req, va, lkHit, lkPaddr, e[27], e[26:0]);
    end
  endtask

  task automatic fill(logic [18:0] v, logic [14:0] p, logic val);
    fillEn = 1; fillVpn = v; fillPpn = p; fillValid = val;
    @(posedge clk);
    modelFill(v, p, val);
    @(negedge clk);
    fillEn = 0;
  endtask

  task automatic flush(logic alsoFill);
    flushAll = 1; fillEn = alsoFill; fillVpn = 19'h7; fillPpn = 15'h1; fillValid = 1;
    @(posedge clk);
    for (int i = 0; i < N; i++) mV[i] = 0;
    @(negedge clk);
    flushAll = 0; fillEn = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) begin mV[i] = 0; mVpn[i] = 0; mPpn[i] = 0; end
    mPtr = 0;
    repeat (2) @(posedge clk);
    @(negedge clk); rstN = 1;
    check("R1", 31'h0);
    check("R1", 31'h247C);
    // R2 example from requirement
    fill(19'h00002, 15'h7FFF, 1);
    check("R2", 31'h247C);
    check("R3", 31'h2FFF);
    check("R4", 31'h347C);
    // R5 overwrite existing VPN
    fill(19'h00002, 15'h1234, 1);
    check("R5", 31'h2ABC);
    // R6 second free entry
    fill(19'h00005, 15'h0001, 1);
    check("R6", 31'h5F20);
    check("R6", 31'h2001);
    // R7 round robin: buffer full, victims 0 then 1 then 0
    fill(19'h00009, 15'h0AAA, 1);
    check("R7", 31'h9000);
    check("R7", 31'h2000);
    check("R7", 31'h5000);
    fill(19'h0000A, 15'h0BBB, 1);
    check("R7", 31'h5000);
    check("R7", 31'hA123);
    fill(19'h0000B, 15'h0CCC, 1);
    check("R7", 31'h9000);
    check("R7", 31'hB456);
    // R8 flush with simultaneous fill
    flush(1);
    check("R8", 31'hA123);
    check("R8", 31'h7000);
    // R9 invalid fill never hits
    fill(19'h00033, 15'h0777, 0);
    check("R9", 31'h33333);
    fill(19'h00044, 15'h0888, 1);
    check("R9", 31'h44000);
    // random mix over small VPN space
    for (int k = 0; k < 400; k++) begin
      int op = $urandom_range(0, 9);
      if (op < 4) fill(19'($urandom_range(0, 5)), 15'($urandom), 1'($urandom_range(0, 4) != 0));
      else if (op == 4) flush(1'($urandom_range(0, 1)));
      else check("R4", {19'($urandom_range(0, 5)), 12'($urandom)});
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule